// File: doc/BRIEF.md
# Reloadable Timer with Watchdog Reset

This block is an 8-bit up-counting timer for a microcontroller with a 4-bit data bus. A free-running prescaler divides the system clock by one of eight ratios and delivers count pulses to the counter. When a pulse arrives while the counter holds 0xFF, the block records an overflow. The counter then either reloads from a load register or restarts from zero, and an interrupt request flag is set.

Software reaches the timer through four nibble addresses. Two consecutive addresses carry the 8-bit value, lower nibble first. At those addresses a write goes to the load register and a read returns the live count. Writing the upper nibble also restarts the counter from the full load value at once. Software uses this to service the watchdog before the counter can overflow. A write-only mode register selects the ratio and the overflow behaviour. A control address holds the interrupt flag and a watchdog-enable flag that can only be set. While that enable is set, an overflow turns into a one-cycle system reset request.

Top module: `reload_wdt_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, load register, mode register, interrupt flag and watchdog enable all become 0, and `sys_reset_req` is 0.
- R2: Address 0 holds the lower nibble and address 1 holds the upper nibble of the 8-bit value. A read of either address returns that nibble of the live counter. A write to address 0 changes only the load register's lower nibble and leaves the counter untouched.
- R3: A write to address 1 loads {wdata, load register lower nibble} into both the load register and the counter at that same clock edge. The write also clears the prescaler, and it takes priority over a count pulse in the same cycle.
- R4: Mode bits [2:0] select the division ratio: 0→2, 1→4, 2→8, 3→32, 4→128, 5→512, 6→1024, 7→2048. The first increment comes exactly ratio edges after a restart, and one increment follows every ratio edges after that.
- R5: On overflow with mode bit 3 = 1 (auto-reload), the counter takes the load register value.
- R6: On overflow with mode bit 3 = 0, the counter becomes 0x00.
- R7: Every overflow sets the interrupt flag (`irq_flag` and bit 0 of address 3). A write to address 3 with bit 0 = 0 clears the flag, and bit 0 = 1 has no effect. An overflow in the same cycle as a clear wins.
- R8: The watchdog enable (bit 1 of address 3) is set by a write to address 3 with bit 1 = 1. A write with bit 1 = 0 leaves it unchanged, and only reset clears it. Bits 3:2 of address 3 read 0.
- R9: An overflow while the watchdog enable is set drives `sys_reset_req` high for exactly the one cycle that follows the overflow edge. At all other times it stays low.
- R10: The mode register is written at address 2. Reads of address 2 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 2 | Nibble register address |
| wdata | input | 4 | Write data nibble |
| rd_data | output | 4 | Combinational read data for `addr` |
| irq_flag | output | 1 | Timer interrupt request flag |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
Reads are combinational, so a register value is valid in the cycle after the edge that wrote it. The counter, the interrupt flag and the reset request all change at the edge that captures an upper-nibble write or an overflow. After an upper-nibble restart, the counter reads load + floor(n / ratio) once n edges have passed. The bench counts edges from the write's capture edge and samples every value at the falling edge, so each expected value follows from an exact edge count. Around an overflow the bench samples at n = 1, 2 and 3. This places the interrupt flag and the single reset pulse at the edge where they are due and confirms the pulse is gone one cycle later.

// File: rtl/timer_pkg.sv
// Package timer_pkg
// Shared widths, register addresses and the prescaler tap table for the
// reloadable watchdog timer. Assumes an 8-bit counter split into two nibbles.
package timer_pkg;
    localparam int NIB_W = 4;
    localparam int CNT_W = 2 * NIB_W;
    localparam int PRE_W = 11;   // enough for the largest ratio, 2048
    localparam int ADR_W = 2;

    localparam logic [ADR_W-1:0] ADDR_CNT_LO = 2'd0;
    localparam logic [ADR_W-1:0] ADDR_CNT_HI = 2'd1;
    localparam logic [ADR_W-1:0] ADDR_MODE   = 2'd2;
    localparam logic [ADR_W-1:0] ADDR_CTRL   = 2'd3;

    // Mode register layout: bit 3 auto-reload, bits 2:0 ratio select
    typedef struct packed {
        logic       reload_en;
        logic [2:0] ratio_sel;
    } mode_t;

    // Map a ratio select code to log2 of the division ratio
    function automatic logic [3:0] tap_shift(input logic [2:0] sel);
        case (sel)
            3'd0:    tap_shift = 4'd1;
            3'd1:    tap_shift = 4'd2;
            3'd2:    tap_shift = 4'd3;
            3'd3:    tap_shift = 4'd5;
            3'd4:    tap_shift = 4'd7;
            3'd5:    tap_shift = 4'd9;
            3'd6:    tap_shift = 4'd10;
            default: tap_shift = 4'd11;
        endcase
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Module tmr_prescaler
// Free-running divider that pulses `tick` for one cycle every 2**shift
// clocks, where shift comes from the ratio select. A restart clears it, so
// the first tick after a restart comes ratio-1 cycles later.
// Assumes PRE_W is at least the largest shift (11).
module tmr_prescaler
    import timer_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] ratio_sel,
    output logic       tick
);
    localparam logic [W-1:0] PONE = W'(1);

    logic [W-1:0] div_q;
    logic [W:0]   span;
    logic [W-1:0] mask;

    // Build the low-bit mask for the selected ratio
    always_comb begin
        span = {{W{1'b0}}, 1'b1} << tap_shift(ratio_sel);
        mask = span[W-1:0] - PONE;
    end

    // A tick fires when all masked bits of the divider are ones
    assign tick = &(div_q | ~mask);

    // Advance the divider, or clear it on restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) div_q <= '0;
        else                   div_q <= div_q + PONE;
    end

    // Every ratio is at least 2, so ticks never come back to back
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
// Module tmr_counter
// 8-bit up counter. It is loaded directly on restart and steps on each tick.
// On a tick at all-ones it flags overflow and then either reloads or clears.
// Assumes restart takes priority over tick in the same cycle.
module tmr_counter
    import timer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] restart_val,
    input  logic         reload_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         overflow
);
    localparam logic [W-1:0] CONE = W'(1);

    // Overflow: a pulse that arrives at all-ones and is not masked by a restart
    assign overflow = tick && !restart && (&count);

    // Counter update with restart > overflow > increment priority
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (restart)  count <= restart_val;
        else if (overflow) count <= reload_en ? load_val : '0;
        else if (tick)     count <= count + CONE;
    end

    assert_restart_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == $past(restart_val));
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && !(&count)) |=> count == $past(count) + CONE);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count));
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && reload_en) |=> count == $past(load_val));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !reload_en) |=> count == '0);
endmodule

// File: rtl/tmr_regs.sv
// Module tmr_regs
// Nibble register decode: the load register, the mode register, the
// interrupt flag, the set-only watchdog enable and the reset-request pulse.
// Assumes one write per strobe cycle and an 8-bit value of two nibbles.
module tmr_regs
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    input  logic             overflow,
    output logic [CNT_W-1:0] load_val,
    output mode_t            mode,
    output logic             restart,
    output logic [CNT_W-1:0] restart_val,
    output logic             irq,
    output logic             wden,
    output logic             reset_req
);
    logic wr_lo, wr_mode, wr_ctrl;

    // Decode the write strobes
    always_comb begin
        wr_lo   = wr_en && (addr == ADDR_CNT_LO);
        restart = wr_en && (addr == ADDR_CNT_HI);
        wr_mode = wr_en && (addr == ADDR_MODE);
        wr_ctrl = wr_en && (addr == ADDR_CTRL);
        restart_val = {wdata, load_val[NIB_W-1:0]};
    end

    // Load register: nibble writes; an upper write takes the full value
    always_ff @(posedge clk) begin
        if (!rst_n)       load_val <= '0;
        else if (restart) load_val <= restart_val;
        else if (wr_lo)   load_val[NIB_W-1:0] <= wdata;
    end

    // Mode register: write-only ratio select and reload enable
    always_ff @(posedge clk) begin
        if (!rst_n)       mode <= '0;
        else if (wr_mode) mode <= mode_t'(wdata);
    end

    // Interrupt flag: set by overflow, cleared by writing 0 to bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq <= 1'b0;
        else if (overflow)             irq <= 1'b1;
        else if (wr_ctrl && !wdata[0]) irq <= 1'b0;
    end

    // Watchdog enable: set-only, cleared by reset alone
    always_ff @(posedge clk) begin
        if (!rst_n)                   wden <= 1'b0;
        else if (wr_ctrl && wdata[1]) wden <= 1'b1;
    end

    // Reset request: registered one-cycle pulse per guarded overflow
    always_ff @(posedge clk) begin
        if (!rst_n) reset_req <= 1'b0;
        else        reset_req <= overflow && wden;
    end

    assert_irq_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> irq);
    assert_irq_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_ctrl) |=> irq);
    assert_wden_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wden |=> wden);
    assert_req_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && wden) |=> reset_req);
    assert_req_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && wden) |=> !reset_req);
    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
endmodule

// File: rtl/reload_wdt_timer.sv
// Module reload_wdt_timer
// Top level: connects the register decode, the prescaler and the counter,
// and drives the combinational nibble read port.
// Assumes a single bus master and synchronous active-low reset.
module reload_wdt_timer
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ADR_W-1:0] addr,
    input  logic [NIB_W-1:0] wdata,
    output logic [NIB_W-1:0] rd_data,
    output logic             irq_flag,
    output logic             sys_reset_req
);
    logic [CNT_W-1:0] load_val, restart_val, count;
    mode_t            mode;
    logic             restart, tick, overflow, irq, wden;

    tmr_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .overflow    (overflow),
        .load_val    (load_val),
        .mode        (mode),
        .restart     (restart),
        .restart_val (restart_val),
        .irq         (irq),
        .wden        (wden),
        .reset_req   (sys_reset_req)
    );

    tmr_prescaler #(.W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .ratio_sel (mode.ratio_sel),
        .tick      (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .restart     (restart),
        .restart_val (restart_val),
        .reload_en   (mode.reload_en),
        .load_val    (load_val),
        .count       (count),
        .overflow    (overflow)
    );

    // Read mux: counter nibbles, mode reads zero, control flags
    always_comb begin
        case (addr)
            ADDR_CNT_LO: rd_data = count[NIB_W-1:0];
            ADDR_CNT_HI: rd_data = count[CNT_W-1:NIB_W];
            ADDR_CTRL:   rd_data = {2'b00, wden, irq};
            default:     rd_data = '0;
        endcase
    end

    assign irq_flag = irq;

    assert_mode_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_MODE) |-> rd_data == '0);
endmodule

// File: tb/tb_reload_wdt_timer.sv
module tb_reload_wdt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [3:0] wdata = 4'd0;
    logic [3:0] rd_data;
    logic       irq_flag;
    logic       sys_reset_req;

    int checks = 0;
    int fails  = 0;
    int req_seen = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    reload_wdt_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .irq_flag(irq_flag),
        .sys_reset_req(sys_reset_req)
    );

    // Vectors: {mode, load, edges after restart, expected count}
    localparam int NV = 9;
    localparam logic [35:0] VECS [NV] = '{
        {4'h0, 8'h10, 16'd6,    8'h13},
        {4'h1, 8'h20, 16'd9,    8'h22},
        {4'h2, 8'hA5, 16'd17,   8'hA7},
        {4'h3, 8'h00, 16'd100,  8'h03},
        {4'h8, 8'hFE, 16'd6,    8'hFF},
        {4'h0, 8'hFE, 16'd6,    8'h01},
        {4'h4, 8'h7F, 16'd300,  8'h81},
        {4'h7, 8'h01, 16'd4100, 8'h03},
        {4'h9, 8'hF0, 16'd80,   8'hF4}
    };

    always @(negedge clk) if (sys_reset_req) req_seen++;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Write one nibble; returns at the falling edge after the capture edge
    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [3:0] d);
        addr = a; #1; d = rd_data;
    endtask

    task automatic rd_count(output logic [7:0] c);
        logic [3:0] lo, hi;
        rd(2'd0, lo); rd(2'd1, hi);
        c = {hi, lo};
    endtask

    task automatic rd_ctrl(output logic [7:0] c);
        logic [3:0] s;
        rd(2'd3, s);
        c = {4'h0, s};
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state observed while reset is held
        repeat (3) @(negedge clk);
        rd_count(v);  check("R1 count in reset", v, 8'h00);
        rd_ctrl(v);   check("R1 ctrl in reset", v, 8'h00);
        check("R1 reset req", {7'd0, sys_reset_req}, 8'h00);
        rst_n = 1'b1;

        // R4/R5/R6: vector table
        for (int i = 0; i < NV; i++) begin
            wr(2'd2, VECS[i][35:32]);
            wr(2'd0, VECS[i][27:24]);
            wr(2'd1, VECS[i][31:28]);
            wait_edges(int'(VECS[i][23:8]));
            rd_count(v);
            check($sformatf("R4 R5 R6 vector %0d", i), v, VECS[i][7:0]);
        end

        // R2/R3: low write leaves counter, high write merges both nibbles
        wr(2'd2, 4'h7);
        wr(2'd0, 4'h5);
        wr(2'd1, 4'h5);
        rd_count(v);  check("R3 restart value", v, 8'h55);
        wr(2'd0, 4'hA);
        rd_count(v);  check("R2 low write no counter change", v, 8'h55);
        wr(2'd1, 4'hC);
        rd_count(v);  check("R3 merged restart", v, 8'hCA);

        // R7: clear flag, writing 1 to bit 0 has no effect
        wr(2'd3, 4'h0);
        rd_ctrl(v);   check("R7 flag cleared", v, 8'h00);
        wr(2'd3, 4'h1);
        rd_ctrl(v);   check("R7 write one ignored", v, 8'h00);

        // R6/R7: overflow timing at ratio 2 from 0xFF
        wr(2'd2, 4'h0);
        wr(2'd0, 4'hF);
        wr(2'd1, 4'hF);
        wait_edges(1);
        rd_count(v);  check("R6 before overflow", v, 8'hFF);
        check("R7 flag before overflow", {7'd0, irq_flag}, 8'h00);
        wait_edges(1);
        rd_count(v);  check("R6 after overflow", v, 8'h00);
        check("R7 flag after overflow", {7'd0, irq_flag}, 8'h01);
        check("R9 no req without enable", {7'd0, sys_reset_req}, 8'h00);

        // R8: set-only watchdog enable
        wr(2'd3, 4'h2);
        rd_ctrl(v);   check("R8 enable set", v, 8'h02);
        wr(2'd3, 4'h0);
        rd_ctrl(v);   check("R8 zero write ignored", v, 8'h02);

        // R9: servicing before overflow keeps request low
        req_seen = 0;
        wr(2'd0, 4'h0);
        for (int k = 0; k < 5; k++) begin
            wr(2'd1, 4'h0);
            wait_edges(100);
        end
        check("R9 serviced no pulse", 8'(req_seen), 8'h00);

        // R9: guarded overflow gives one pulse
        wr(2'd0, 4'hF);
        wr(2'd1, 4'hF);
        wait_edges(1);
        check("R9 low before overflow", {7'd0, sys_reset_req}, 8'h00);
        wait_edges(1);
        check("R9 pulse after overflow", {7'd0, sys_reset_req}, 8'h01);
        wait_edges(1);
        check("R9 pulse one cycle", {7'd0, sys_reset_req}, 8'h00);

        // R10: mode reads zero
        rd(2'd2, v[3:0]); check("R10 mode reads zero", {4'h0, v[3:0]}, 8'h00);

        // R1/R8: reset clears the watchdog enable
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        rd_ctrl(v);   check("R1 R8 reset clears enable", v, 8'h00);
        rd_count(v);  check("R1 count cleared", v, 8'h00);
        rst_n = 1'b1;

        finish_run();
    end
endmodule